// File: doc/BRIEF.md
# Cut-Through Output Forwarding Controller

This block sits on one output port of a packet-switched router and decides, packet by packet, how flits leave that port. Each packet is a header flit, any number of body flits, and a closing tail flit; a one-flit packet carries a distinct tag. The header states how many flits the packet holds. When a header arrives, the controller compares that length with the free-space count the downstream router announces. If the whole packet fits, every flit of the packet goes straight through with a single register stage of delay. The controller never waits for the whole packet to arrive first.

If the packet does not fit, the controller absorbs all of its flits into a local buffer sized for one packet of the largest allowed length. Once the tail is stored, the upstream channel is held off. The controller then waits until the announced free space covers the stored packet and sends the stored flits out back to back. Routing decisions and crossbar arbitration are made elsewhere.

Top module: `vct_fwd`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Flit tags on `in_type`/`out_type` are 2'b01 header, 2'b00 body, 2'b10 tail, 2'b11 single-flit packet. A header carries the packet length in flits in `in_data[LW-1:0]`, where LW = $clog2(MAX_LEN+1). A single-flit packet has length 1 whatever its data.
- R3: If `dn_free` is at least the packet length when the header is accepted, each flit of that packet appears on the output, with tag and data unchanged, in the cycle after the flit is accepted.
- R4: If `dn_free` is below the packet length when the header is accepted, no flit of that packet reaches the output while the packet is being absorbed.
- R5: Once a buffered packet's tail, or a buffered single-flit packet, has been accepted, `in_ready` stays 0 until the buffered packet has been sent.
- R6: A buffered packet starts leaving only after `dn_free` has reached its header length. Its flits are then sent one per cycle with no gap, in arrival order, and with tags and data unchanged.
- R7: In the cycle after a buffered packet's last flit is sent, `in_ready` is 1 again.
- R8: A single-flit packet passes straight through when `dn_free` is at least 1. When `dn_free` is 0 it is buffered and handled as in R5 and R6.
- R9: Body or tail flits presented when no packet is open are accepted and dropped. Nothing appears on the output for them.
- R10: A `dn_free` exactly equal to the packet length counts as enough room for straight-through forwarding.
- R11: On a straight-through packet, cycles in which upstream presents no flit give cycles with `out_valid` low. The other flits keep their one-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream flit present |
| in_ready | output | 1 | Controller accepts the upstream flit this cycle |
| in_type | input | 2 | Upstream flit tag |
| in_data | input | DW | Upstream flit payload; holds the length field in a header |
| dn_free | input | FREE_W | Free flit slots announced by the downstream router |
| out_valid | output | 1 | Downstream flit present |
| out_type | output | 2 | Downstream flit tag |
| out_data | output | DW | Downstream flit payload |

## Verification
Packets are offered with ample room, with room exactly equal to their length, and with too little room. Together these separate the straight-through path from the absorb-and-release path and pin down the boundary of the space comparison. Buffered packets are held while the announced space stays short and are then released by raising it. This shows that the upstream stall lasts exactly as long as the stored packet and that the release is a gap-free burst in the original order. Single-flit packets, stray body and tail flits with no open packet, a maximum-length packet and a straight-through packet with upstream idle cycles cover the tag handling, the drop rule, the full buffer and the preservation of gaps.

// File: rtl/vct_pkg.sv
package vct_pkg;

  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PASS  = 3'd1,
    ST_FILL  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DRAIN = 3'd4
  } fwd_state_e;

endpackage

// File: rtl/vct_pkt_ram.sv
module vct_pkt_ram #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/vct_admit.sv
module vct_admit #(
  parameter int LW     = 4,
  parameter int FREE_W = 6,
  localparam int CW    = (LW > FREE_W) ? LW : FREE_W
) (
  input  logic [1:0]        kind,
  input  logic [LW-1:0]     len_field,
  input  logic [FREE_W-1:0] dn_free,
  output logic [LW-1:0]     pkt_len,
  output logic              fits
);
  import vct_pkg::*;

  logic [CW-1:0] need_w;
  logic [CW-1:0] have_w;

  always_comb begin
    if (kind == FK_SOLO) pkt_len = LW'(1);
    else                 pkt_len = len_field;
    need_w = CW'(pkt_len);
    have_w = CW'(dn_free);
    fits   = (need_w <= have_w);
  end

endmodule

// File: rtl/vct_fwd.sv
module vct_fwd #(
  parameter int DW      = 16,
  parameter int MAX_LEN = 8,
  parameter int FREE_W  = 6,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int AW     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int FW     = DW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_type,
  input  logic [DW-1:0]     in_data,
  input  logic [FREE_W-1:0] dn_free,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [DW-1:0]     out_data
);
  import vct_pkg::*;

  fwd_state_e    state_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] wr_ptr_q;
  logic [LW-1:0] rd_ptr_q;
  logic          out_valid_q;
  logic          out_sel_q;
  logic [FW-1:0] pass_q;
  logic [FW-1:0] ram_q;

  logic          accept;
  logic          is_head;
  logic          is_solo;
  logic          is_tail;
  logic [LW-1:0] hdr_len;
  logic          hdr_fits;
  logic          wait_fits;
  logic          ram_we;
  logic [AW-1:0] ram_wa;
  logic          ram_re;
  logic [FW-1:0] flit_in;
  logic          room_left;

  assign in_ready = (state_q == ST_IDLE) || (state_q == ST_PASS) ||
                    (state_q == ST_FILL);
  assign accept   = in_valid && in_ready;
  assign is_head  = (in_type == FK_HEAD) || (in_type == FK_SOLO);
  assign is_solo  = (in_type == FK_SOLO);
  assign is_tail  = (in_type == FK_TAIL);
  assign flit_in  = {in_type, in_data};
  assign room_left = (wr_ptr_q < LW'(MAX_LEN));

  vct_admit #(.LW(LW), .FREE_W(FREE_W)) u_admit (
    .kind      (in_type),
    .len_field (in_data[LW-1:0]),
    .dn_free   (dn_free),
    .pkt_len   (hdr_len),
    .fits      (hdr_fits)
  );

  logic [LW-1:0] wait_len_unused;
  vct_admit #(.LW(LW), .FREE_W(FREE_W)) u_recheck (
    .kind      (FK_HEAD),
    .len_field (len_q),
    .dn_free   (dn_free),
    .pkt_len   (wait_len_unused),
    .fits      (wait_fits)
  );

  always_comb begin
    ram_we = 1'b0;
    ram_wa = wr_ptr_q[AW-1:0];
    if (state_q == ST_IDLE && accept && is_head && !hdr_fits) begin
      ram_we = 1'b1;
      ram_wa = '0;
    end else if (state_q == ST_FILL && accept && room_left) begin
      ram_we = 1'b1;
    end
  end

  assign ram_re = (state_q == ST_DRAIN);

  vct_pkt_ram #(.W(FW), .DEPTH(MAX_LEN)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_wa),
    .wr_data (flit_in),
    .rd_en   (ram_re),
    .rd_addr (rd_ptr_q[AW-1:0]),
    .rd_data (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      cnt_q       <= '0;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      out_valid_q <= 1'b0;
      out_sel_q   <= 1'b0;
      pass_q      <= '0;
    end else begin
      out_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && is_head) begin
            len_q <= hdr_len;
            if (hdr_fits) begin
              out_valid_q <= 1'b1;
              out_sel_q   <= 1'b0;
              pass_q      <= flit_in;
              state_q     <= is_solo ? ST_IDLE : ST_PASS;
            end else begin
              wr_ptr_q <= LW'(1);
              cnt_q    <= LW'(1);
              state_q  <= is_solo ? ST_WAIT : ST_FILL;
            end
          end
        end
        ST_PASS: begin
          if (accept) begin
            out_valid_q <= 1'b1;
            out_sel_q   <= 1'b0;
            pass_q      <= flit_in;
            if (is_tail) state_q <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (accept) begin
            if (room_left) wr_ptr_q <= wr_ptr_q + LW'(1);
            if (is_tail) begin
              cnt_q   <= room_left ? wr_ptr_q + LW'(1) : LW'(MAX_LEN);
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (wait_fits) begin
            rd_ptr_q <= '0;
            state_q  <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          out_valid_q <= 1'b1;
          out_sel_q   <= 1'b1;
          rd_ptr_q    <= rd_ptr_q + LW'(1);
          if (rd_ptr_q == cnt_q - LW'(1)) begin
            wr_ptr_q <= '0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [FW-1:0] out_flit;
  assign out_flit  = out_sel_q ? ram_q : pass_q;
  assign out_valid = out_valid_q;
  assign out_type  = out_flit[FW-1 -: 2];
  assign out_data  = out_flit[DW-1:0];

endmodule

// File: rtl/vct_fwd_chk.sv
module vct_fwd_chk #(
  parameter int DW     = 16,
  parameter int LW     = 4,
  parameter int FREE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_type,
  input logic [DW-1:0]     in_data,
  input logic [FREE_W-1:0] dn_free,
  input logic              out_valid,
  input logic [DW-1:0]     out_data,
  input logic [2:0]        state_i,
  input logic [LW-1:0]     len_i,
  input logic              fits_i
);
  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_FILL  = 3'd2;
  localparam logic [2:0] S_WAIT  = 3'd3;
  localparam logic [2:0] S_DRAIN = 3'd4;

  logic hdr_in;
  assign hdr_in = in_valid && in_ready && (in_type == 2'b01 || in_type == 2'b11);

  // R3: admitted header leaves one cycle later with its data
  p_cut_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_IDLE && hdr_in && fits_i) |=> (out_valid && out_data == $past(in_data)));

  // R4: nothing is sent while a packet is absorbed
  p_quiet_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_FILL) |-> !out_valid);

  // R5: storing the tail closes the upstream channel
  p_stall_after_tail_r5: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_FILL && in_valid && in_ready && in_type == 2'b10) |=> !in_ready);

  // R6: release only with enough announced room
  p_release_room_r6: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_DRAIN && $past(state_i) == S_WAIT) |->
      ({{(32-FREE_W){1'b0}}, $past(dn_free)} >= {{(32-LW){1'b0}}, len_i}));

  // R6: drained flits leave with no gap
  p_drain_gapless_r6: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_DRAIN) |=> out_valid);

  // R9: stray body or tail flits produce no output
  p_stray_dropped_r9: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_IDLE && in_valid && (in_type == 2'b00 || in_type == 2'b10)) |=> !out_valid);

endmodule

bind vct_fwd vct_fwd_chk #(.DW(DW), .LW(LW), .FREE_W(FREE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_type   (in_type),
  .in_data   (in_data),
  .dn_free   (dn_free),
  .out_valid (out_valid),
  .out_data  (out_data),
  .state_i   (state_q),
  .len_i     (len_q),
  .fits_i    (hdr_fits)
);

// File: tb/vct_fwd_tb.sv
module vct_fwd_tb;
  localparam int DW = 16;
  localparam int MAX_LEN = 8;
  localparam int FREE_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_type = 2'b00;
  logic [DW-1:0]     in_data = '0;
  logic [FREE_W-1:0] dn_free = '0;
  logic              out_valid;
  logic [1:0]        out_type;
  logic [DW-1:0]     out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [DW+1:0] expq[$];

  always #5 clk = ~clk;

  vct_fwd #(.DW(DW), .MAX_LEN(MAX_LEN), .FREE_W(FREE_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_data(in_data), .dn_free(dn_free),
    .out_valid(out_valid), .out_type(out_type), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: order, tag and data of every output flit (R3/R6)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected output flit", {out_type, out_data}, 0);
      end else begin
        logic [DW+1:0] e;
        e = expq.pop_front();
        check({out_type, out_data} == e, "R3/R6 flit order and content",
              {out_type, out_data}, e);
      end
    end
  end

  // driver: offer one flit, wait until taken, push expectation
  task automatic put(input logic [1:0] t, input logic [DW-1:0] d, input bit keep);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_type  = t;
    in_data  = d;
    if (keep) expq.push_back({t, d});
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] hdr(input int len, input int tagv);
    return DW'((tagv << 8) | len);
  endfunction

  // buffered packet: nothing out while absorbing
  task automatic buffered_pkt(input int len, input int base);
    put(2'b01, hdr(len, base), 1'b1);
    check(!out_valid, "R4 header absorbed", out_valid, 0);
    for (int i = 1; i < len - 1; i++) begin
      put(2'b00, DW'(base * 16 + i), 1'b1);
      check(!out_valid, "R4 body absorbed", out_valid, 0);
    end
    put(2'b10, DW'(base * 16 + 15), 1'b1);
    check(!out_valid, "R4 tail absorbed", out_valid, 0);
    idle_in();
  endtask

  // hold while room is short, then release and count the burst
  task automatic release_and_count(input int len);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!in_ready, "R5 upstream held", in_ready, 0);
      check(!out_valid, "R6 no release without room", out_valid, 0);
    end
    dn_free = FREE_W'(len);
    begin
      int waitc = 0;
      int run = 0;
      @(negedge clk);
      while (!out_valid && waitc < 5) begin
        @(negedge clk);
        waitc++;
      end
      while (out_valid) begin
        run++;
        @(negedge clk);
      end
      check(run == len, "R6 gapless burst length", run, len);
      check(in_ready, "R7 ready after drain", in_ready, 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    dn_free = FREE_W'(16);
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", out_valid, 0);
    check(in_ready, "R1 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);

    // R3 R2: straight-through, one-cycle delay per flit
    put(2'b01, hdr(3, 1), 1'b1);
    check(out_valid && out_type == 2'b01, "R3 header next cycle", {out_valid, out_type}, 3'b101);
    put(2'b00, 16'h1111, 1'b1);
    check(out_valid && out_data == 16'h1111, "R3 body next cycle", out_data, 16'h1111);
    put(2'b10, 16'h1112, 1'b1);
    check(out_valid && out_type == 2'b10, "R3 tail next cycle", {out_valid, out_type}, 3'b110);
    idle_in();

    // R10: exact room is enough
    dn_free = FREE_W'(4);
    put(2'b01, hdr(4, 2), 1'b1);
    check(out_valid, "R10 exact room passes", out_valid, 1);
    put(2'b00, 16'h2221, 1'b1);
    put(2'b00, 16'h2222, 1'b1);
    put(2'b10, 16'h2223, 1'b1);
    check(out_valid && out_data == 16'h2223, "R10 tail through", out_data, 16'h2223);
    idle_in();

    // R4 R5 R6 R7: one short of room
    dn_free = FREE_W'(3);
    buffered_pkt(4, 3);
    release_and_count(4);

    // R8: single-flit packet, no room then room
    dn_free = '0;
    put(2'b11, 16'h5A5A, 1'b1);
    check(!out_valid, "R8 single buffered", out_valid, 0);
    idle_in();
    release_and_count(1);
    dn_free = FREE_W'(1);
    put(2'b11, 16'h6B6B, 1'b1);
    check(out_valid && out_type == 2'b11, "R8 single straight through", {out_valid, out_type}, 3'b111);
    idle_in();

    // R9: stray body and tail dropped
    dn_free = FREE_W'(16);
    put(2'b00, 16'hDEAD, 1'b0);
    check(!out_valid, "R9 stray body", out_valid, 0);
    put(2'b10, 16'hBEEF, 1'b0);
    check(!out_valid, "R9 stray tail", out_valid, 0);
    check(in_ready, "R9 still idle", in_ready, 1);
    idle_in();

    // R11: upstream gap preserved
    put(2'b01, hdr(3, 7), 1'b1);
    idle_in();
    @(posedge clk);
    #1;
    check(!out_valid, "R11 gap kept", out_valid, 0);
    put(2'b00, 16'h7771, 1'b1);
    check(out_valid && out_data == 16'h7771, "R11 body after gap", out_data, 16'h7771);
    put(2'b10, 16'h7772, 1'b1);
    idle_in();

    // R6: maximum length packet buffered then released
    dn_free = FREE_W'(2);
    buffered_pkt(MAX_LEN, 9);
    release_and_count(MAX_LEN);

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R6 all expected flits seen", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule